// File: doc/BRIEF.md
# Addressed Burst Channel Slave

This block is the board-side end of a shared 32-bit synchronous host channel. Up to sixteen boards hang on one channel, and every one of them is a slave. The host starts every transaction. It sends a control word, then a device address word, then a burst of data words. Each word on the channel is qualified by a valid strobe. The slave decodes the control word. It then decides whether it is the target: either the board identifier equals its fixed slot number, or the word is a broadcast write. A selected slave moves the burst through a simple local device port. Writes come out as per-word write strobes. Reads are served from combinational device read data, which the slave places on the channel.

A board that is not the target still walks through every phase of the transaction. It counts the same number of data words as the target board. This keeps it aligned with the channel, so that it reads the next control word correctly. On reads, a selected slave raises its output enable in a dedicated turnaround cycle before it drives any data. It releases the channel as soon as the last word has been taken.

The state machine has four states:
- **IDLE** waits for a control word and moves to ADDR.
- **ADDR** waits for the address word. It moves to TURN for a read and to DATA for a write.
- **TURN** always lasts exactly one cycle and then moves to DATA.
- **DATA** counts valid words. On the last word it returns to IDLE.

Top module: `chsl_slave`

## Requirements
- R1: While reset is held and right after it is released, the block is in IDLE. `bus_oe`, `bus_dout`, `dev_wr_en` and `dev_rd_en` are all zero.
- R2: The control word fields are:
  - bits [3:0]: board identifier
  - bit 4: broadcast flag
  - bit 5: direction (1 = host reads from board)
  - bits [9:6]: operation code
  - bits [25:10]: burst length in words

  An identifier equal to `SLOT_ID` selects the board for either direction.
- R3: A broadcast word with direction 0 (write) selects the board whatever its identifier. A broadcast word with direction 1 selects the board only when the identifier matches.
- R4: An unselected board raises no device strobe and never asserts `bus_oe`. It still consumes exactly the same words as a selected board, so the following control word is decoded correctly.
- R5: The word after the control word is the base address. Data word i (counting from 0) is presented on `dev_addr` as base + i.
- R6: A burst carries the decoded length in words. A length field of 0 means one word. After the last valid data word the block is back in IDLE, with no strobes and `bus_oe` low.
- R7: In a selected write, each valid data word gives one cycle of `dev_wr_en`, with `dev_wdata` equal to the channel word. `dev_rd_en` stays low.
- R8: In a selected read, the cycle after the address word is a turnaround cycle. In it `bus_oe` is high and `bus_dout` is zero. In each later cycle with valid high, `dev_rd_en` is high and `bus_dout` equals `dev_rd_data`. `bus_oe` stays high until the last word is taken.
- R9: In the data phase, a cycle with valid low raises no strobe and does not advance the word position.
- R10: During the data phase, `dev_op` shows the operation code of the current control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host strobe qualifying the channel word |
| bus_din | input | 32 | Channel word driven by the host |
| bus_dout | output | 32 | Read data driven onto the channel, zero when not driving |
| bus_oe | output | 1 | Channel output enable of this board |
| dev_addr | output | 32 | Local device address of the current data word |
| dev_op | output | 4 | Operation code of the current transaction |
| dev_wr_en | output | 1 | Local write strobe |
| dev_wdata | output | 32 | Local write data |
| dev_rd_en | output | 1 | Local read strobe |
| dev_rd_data | input | 32 | Combinational local read data for `dev_addr` |

## Verification
The bench builds the block with `SLOT_ID` = 5 and the default 32-bit word. It sweeps all sixteen board identifiers, with and without the broadcast flag, in both directions. Every board in that sweep therefore meets the slot-match, broadcast-write, broadcast-read and unselected cases. The transactions run back to back, so any slip in word counting shows up as a misdecoded next transaction. Burst lengths cycle through 0 to 3, and one 40-word write is added. Stall cycles are mixed into the data phases to exercise the hold of the word position.

// File: rtl/chsl_pkg.sv
package chsl_pkg;

    localparam int ID_W  = 4;
    localparam int OP_W  = 4;
    localparam int LEN_W = 16;

    // Control word layout, LSB first: id, broadcast, direction, op, length
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [OP_W-1:0]  op;
        logic             rd;
        logic             bcast;
        logic [ID_W-1:0]  id;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_TURN = 2'd2,
        ST_DATA = 2'd3
    } chsl_state_e;

endpackage

// File: rtl/chsl_decode.sv
module chsl_decode
    import chsl_pkg::*;
#(
    parameter int unsigned SLOT_ID = 0
) (
    input  logic [CTL_W-1:0] ctl_word,
    output logic             sel,
    output logic             rd,
    output logic [OP_W-1:0]  op,
    output logic [LEN_W-1:0] last_idx
);

    ctl_word_t ctl;
    logic      id_hit;

    always_comb begin
        ctl      = ctl_word_t'(ctl_word);
        id_hit   = (ctl.id == ID_W'(SLOT_ID));
        // a broadcast only selects for writes: several boards may not drive
        sel      = id_hit || (ctl.bcast && !ctl.rd);
        rd       = ctl.rd;
        op       = ctl.op;
        last_idx = (ctl.len == '0) ? '0 : ctl.len - LEN_W'(1);
    end

endmodule

// File: rtl/chsl_beat_ctr.sv
module chsl_beat_ctr
    import chsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_last,
    input  logic             step,
    output logic [LEN_W-1:0] count,
    output logic             at_last
);

    logic [LEN_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            last_q <= '0;
        end else if (load) begin
            count  <= '0;
            last_q <= load_last;
        end else if (step) begin
            count  <= at_last ? '0 : count + LEN_W'(1);
        end
    end

    assign at_last = (count == last_q);

    // R6
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= last_q);

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count));

    // R5
    count_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !at_last) |=> (count == $past(count) + LEN_W'(1)));

endmodule

// File: rtl/chsl_fsm.sv
module chsl_fsm
    import chsl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic        rd_dir,
    input  logic        at_last,
    output chsl_state_e state
);

    chsl_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (valid) state_nx = ST_ADDR;
            ST_ADDR: if (valid) state_nx = rd_dir ? ST_TURN : ST_DATA;
            ST_TURN: state_nx = ST_DATA;
            ST_DATA: if (valid && at_last) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R1
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !valid) |=> (state == ST_IDLE));

    // R8
    turn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |=> (state == ST_DATA));

    // R6
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && valid && at_last) |=> (state == ST_IDLE));

endmodule

// File: rtl/chsl_slave.sv
module chsl_slave
    import chsl_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int unsigned SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic [DATA_W-1:0] dev_addr,
    output logic [OP_W-1:0]   dev_op,
    output logic              dev_wr_en,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_rd_en,
    input  logic [DATA_W-1:0] dev_rd_data
);

    chsl_state_e      state;
    logic             dec_sel, dec_rd;
    logic [OP_W-1:0]  dec_op;
    logic [LEN_W-1:0] dec_last;
    logic [LEN_W-1:0] count;
    logic             at_last;
    logic             sel_q, rd_q;
    logic [OP_W-1:0]  op_q;
    logic [DATA_W-1:0] base_q;
    logic             take_ctl, take_addr, beat;

    assign take_ctl  = (state == ST_IDLE) && bus_valid;
    assign take_addr = (state == ST_ADDR) && bus_valid;
    assign beat      = (state == ST_DATA) && bus_valid;

    chsl_decode #(.SLOT_ID(SLOT_ID)) u_decode (
        .ctl_word (bus_din[CTL_W-1:0]),
        .sel      (dec_sel),
        .rd       (dec_rd),
        .op       (dec_op),
        .last_idx (dec_last)
    );

    chsl_beat_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_ctl),
        .load_last (dec_last),
        .step      (beat),
        .count     (count),
        .at_last   (at_last)
    );

    chsl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (bus_valid),
        .rd_dir  (rd_q),
        .at_last (at_last),
        .state   (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            rd_q   <= 1'b0;
            op_q   <= '0;
            base_q <= '0;
        end else begin
            if (take_ctl) begin
                sel_q <= dec_sel;
                rd_q  <= dec_rd;
                op_q  <= dec_op;
            end
            if (take_addr) base_q <= bus_din;
        end
    end

    always_comb begin
        dev_addr  = base_q + DATA_W'(count);
        dev_op    = op_q;
        dev_wdata = bus_din;
        dev_wr_en = beat && sel_q && !rd_q;
        dev_rd_en = beat && sel_q && rd_q;
        bus_oe    = sel_q && rd_q && ((state == ST_TURN) || (state == ST_DATA));
        bus_dout  = (sel_q && rd_q && (state == ST_DATA)) ? dev_rd_data : '0;
    end

    // R8
    turn_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> !dev_rd_en);

    // R4
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dout != '0) |-> bus_oe);

    // R7
    write_not_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_en |-> !bus_oe);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_oe && !dev_wr_en && !dev_rd_en));

endmodule

// File: tb/chsl_slave_tb.sv
module chsl_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_din = '0;
    logic [31:0] bus_dout, dev_addr, dev_wdata, dev_rd_data;
    logic        bus_oe, dev_wr_en, dev_rd_en;
    logic [3:0]  dev_op;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // device model: read data is a fixed function of the address
    assign dev_rd_data = {dev_addr[15:0], ~dev_addr[15:0]};

    chsl_slave #(.DATA_W(32), .SLOT_ID(SLOT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .dev_addr(dev_addr), .dev_op(dev_op),
        .dev_wr_en(dev_wr_en), .dev_wdata(dev_wdata), .dev_rd_en(dev_rd_en),
        .dev_rd_data(dev_rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic quiet_cycle(input string tag);
        @(negedge clk);
        bus_valid = 1'b0;
        bus_din   = '0;
        #1;
        chk({tag, " quiet strobes/oe"}, {29'b0, dev_wr_en, dev_rd_en, bus_oe}, 32'd0);
    endtask

    task automatic run_txn(input int id, input bit bc, input bit rd, input int op,
                           input int len, input logic [31:0] base, input bit gaps);
        bit          exp_sel;
        int          n;
        string       tag;
        logic [31:0] ctrl, ea, wd;
        exp_sel = (id == SLOT) || (bc && !rd);
        n       = (len == 0) ? 1 : len;
        tag     = (id == SLOT) ? "R2" : ((bc && !rd) ? "R3" : "R4");
        ctrl    = (32'(len) << 10) | (32'(op) << 6) | (32'(rd) << 5)
                | (32'(bc) << 4) | 32'(id);

        @(negedge clk);
        bus_valid = 1'b1;
        bus_din   = ctrl;
        #1;
        chk({tag, " control cycle quiet"}, {29'b0, dev_wr_en, dev_rd_en, bus_oe}, 32'd0);

        @(negedge clk);
        bus_din = base;
        #1;
        chk("R8 no drive in address cycle", {31'b0, bus_oe}, 32'd0);

        if (rd) begin
            @(negedge clk);
            bus_valid = 1'b0;
            bus_din   = '0;
            #1;
            chk({tag, "/R8 turnaround oe"}, {31'b0, bus_oe}, {31'b0, exp_sel});
            chk("R8 turnaround dout zero", bus_dout, 32'd0);
        end

        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) begin
                @(negedge clk);
                bus_valid = 1'b0;
                bus_din   = 32'hDEAD0000;
                #1;
                chk("R9 stall no strobe", {30'b0, dev_wr_en, dev_rd_en}, 32'd0);
                chk("R9 stall oe held", {31'b0, bus_oe}, {31'b0, exp_sel && rd});
            end
            @(negedge clk);
            ea        = base + 32'(i);
            wd        = 32'hC0DE0000 + 32'(id << 8) + 32'(i);
            bus_valid = 1'b1;
            bus_din   = wd;
            #1;
            if (!rd) begin
                chk({tag, "/R7 write strobe"}, {31'b0, dev_wr_en}, {31'b0, exp_sel});
                chk("R7 no read strobe on write", {31'b0, dev_rd_en}, 32'd0);
                if (exp_sel) begin
                    chk("R5 write address", dev_addr, ea);
                    chk("R7 write data", dev_wdata, wd);
                    chk("R10 op code", {28'b0, dev_op}, 32'(op));
                end
            end else begin
                chk({tag, "/R8 read strobe"}, {31'b0, dev_rd_en}, {31'b0, exp_sel});
                chk({tag, "/R8 read oe"}, {31'b0, bus_oe}, {31'b0, exp_sel});
                chk("R8 read data", bus_dout,
                    exp_sel ? {ea[15:0], ~ea[15:0]} : 32'd0);
                if (exp_sel) begin
                    chk("R5 read address", dev_addr, ea);
                    chk("R10 op code", {28'b0, dev_op}, 32'(op));
                end
            end
        end
        quiet_cycle("R6 end of burst");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset held", {29'b0, dev_wr_en, dev_rd_en, bus_oe}, 32'd0);
        chk("R1 reset dout", bus_dout, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 after reset", {29'b0, dev_wr_en, dev_rd_en, bus_oe}, 32'd0);

        for (int id = 0; id < 16; id++) begin
            for (int bc = 0; bc < 2; bc++) begin
                for (int rd = 0; rd < 2; rd++) begin
                    run_txn(id, bit'(bc), bit'(rd), (id ^ 9) & 15,
                            (id + 2 * bc + rd) % 4,
                            32'h1000_0000 + 32'(id * 256 + bc * 64 + rd * 32),
                            bit'(id % 2));
                end
            end
        end

        // R6 long burst with stalls, then zero-length read on own slot
        run_txn(SLOT, 1'b0, 1'b0, 3, 40, 32'h2000_0FF0, 1'b1);
        run_txn(SLOT, 1'b0, 1'b1, 12, 0, 32'h3000_0000, 1'b0);
        // R4 unselected long read followed by a selected write stays aligned
        run_txn(2, 1'b0, 1'b1, 1, 7, 32'h4000_0000, 1'b1);
        run_txn(SLOT, 1'b0, 1'b0, 6, 2, 32'h5000_0000, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule